// File: doc/BRIEF.md
# Block Memory Copy and Search Sequencer

This block runs byte-wise block moves and block scans over a byte-addressed memory. A command pulse loads three 16-bit registers and an 8-bit compare value. The registers are a source pointer, a destination pointer and a remaining-count. The pulse also carries four mode bits: scan versus move, ascending versus descending, one step versus run-to-end, and, for moves, drop-bytes-equal-to-the-compare-value. The sequencer then drives a synchronous memory port and updates its registers and four status flags after every byte. The flags are match, count-nonzero, half-borrow and subtract.

A processor core places it beside its register file. The core loads the registers, pulses the start input and waits for the one-cycle done pulse. It then reads back the pointers, the count and the flags. Every memory request is held until the memory raises ready, so slow memories simply stretch the operation.

Top module: `blkmove_engine`

## Requirements
- R1: A move step reads the byte at the source pointer and writes it to the destination pointer. It then adds 1 to both pointers and subtracts 1 from the count. At no time are read and write requested together.
- R2: With the descending mode bit set, a move or scan step subtracts 1 from each pointer it changes instead of adding 1. Pointers wrap modulo 2^16, so 0x0000 steps down to 0xFFFF.
- R3: Every move step clears the half-borrow and subtract flags and leaves the match flag unchanged.
- R4: In run-to-end move mode, steps repeat until the count reaches zero. No step is issued after that.
- R5: In drop-equal mode, a byte equal to the compare value causes no write. The pointers and the count still advance as in a normal step.
- R6: A scan step reads the byte at the source pointer and sets the match flag when it equals the compare value. It sets the subtract flag to 1 and sets the half-borrow flag when the low nibble of the compare value is less than the low nibble of the byte. It then steps the source pointer, subtracts 1 from the count, leaves the destination pointer unchanged and issues no write.
- R7: After each step the count-nonzero flag is 1 if the new count is nonzero and 0 if it is zero.
- R8: In run-to-end scan mode, the sequence stops after the first step that sets the match flag, or after the step that brings the count to zero, whichever comes first.
- R9: A starting count of zero is decremented to 0xFFFF before any zero test, so it stands for 65536 steps.
- R10: While a memory request is not answered by ready, the request, its address and the register state stay unchanged.
- R11: After reset the sequencer is idle, with all registers and flags at 0. Done is high for exactly one cycle when an operation ends. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse, accepted only while idle |
| opSearch | input | 1 | 1 = scan, 0 = move |
| opDown | input | 1 | 1 = descending pointers |
| opRepeat | input | 1 | 1 = run to end, 0 = single step |
| opSkipEq | input | 1 | Move only: do not write bytes equal to the compare value |
| srcIn | input | 16 | Initial source pointer |
| dstIn | input | 16 | Initial destination pointer |
| cntIn | input | 16 | Initial count |
| accIn | input | 8 | Compare value |
| srcOut | output | 16 | Current source pointer |
| dstOut | output | 16 | Current destination pointer |
| cntOut | output | 16 | Current count |
| flagZ | output | 1 | Match flag |
| flagPv | output | 1 | Count-nonzero flag |
| flagH | output | 1 | Half-borrow flag |
| flagN | output | 1 | Subtract flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid while ready is high |
| memReady | input | 1 | Completes the pending request at the clock edge |

## Verification
The bench builds the block with its default 16-bit address and count widths and an 8-bit data width. This puts pointer wrap across 0x0000 within reach of a short descending move, and puts the zero-count wrap to 0xFFFF within reach of a single step. A pseudo-random ready pattern exercises stalls on both reads and writes, and a start pulse is injected in the middle of a stalled run. A behavioural model over a shadow memory predicts every read address, every write and the final register and flag values.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_STEP
  } seqState_t;

  typedef struct packed {
    logic load;      // take initial values from the command inputs
    logic capture;   // latch read data
    logic step;      // advance pointers, count and flags
    logic isSearch;  // step is a scan step
    logic down;      // descending pointers
    logic useDst;    // address the destination pointer
  } ctlStrobe_t;

endpackage

// File: rtl/blkmove_datapath.sv
module blkmove_datapath
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic [AW-1:0] initSrc,
  input  logic [AW-1:0] initDst,
  input  logic [CW-1:0] initCnt,
  input  logic [DW-1:0] initAcc,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          flagZ,
  output logic          flagPv,
  output logic          flagH,
  output logic          flagN,
  output logic          rdMatch,
  output logic          heldMatch,
  output logic          cntLast
);

  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam int            NIB     = (DW >= 4) ? 4 : DW;

  logic [DW-1:0] acc;
  logic [DW-1:0] dataReg;
  logic [AW-1:0] srcNext;
  logic [AW-1:0] dstNext;
  logic          halfBorrow;

  assign srcNext    = ctl.down ? (src - PTR_ONE) : (src + PTR_ONE);
  assign dstNext    = ctl.down ? (dst - PTR_ONE) : (dst + PTR_ONE);
  assign rdMatch    = (memRdata == acc);
  assign heldMatch  = (dataReg == acc);
  assign cntLast    = (cnt == CNT_ONE);
  assign halfBorrow = (acc[NIB-1:0] < dataReg[NIB-1:0]);
  assign memAddr    = ctl.useDst ? dst : src;
  assign memWdata   = dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      src     <= '0;
      dst     <= '0;
      cnt     <= '0;
      acc     <= '0;
      dataReg <= '0;
      flagZ   <= 1'b0;
      flagPv  <= 1'b0;
      flagH   <= 1'b0;
      flagN   <= 1'b0;
    end else begin
      if (ctl.load) begin
        src <= initSrc;
        dst <= initDst;
        cnt <= initCnt;
        acc <= initAcc;
      end
      if (ctl.capture) begin
        dataReg <= memRdata;
      end
      if (ctl.step) begin
        src    <= srcNext;
        cnt    <= cnt - CNT_ONE;
        flagPv <= !cntLast;
        if (ctl.isSearch) begin
          flagZ <= heldMatch;
          flagH <= halfBorrow;
          flagN <= 1'b1;
        end else begin
          dst   <= dstNext;
          flagH <= 1'b0;
          flagN <= 1'b0;
        end
      end
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> cnt == $past(cnt) - CNT_ONE); // R1
  AST_SCAN_DST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.isSearch) |=> dst == $past(dst)); // R6
  AST_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.isSearch) |=> (!flagH && !flagN && flagZ == $past(flagZ))); // R3
  AST_PV_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> flagPv == (cnt != '0)); // R7

endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       opSearch,
  input  logic       opDown,
  input  logic       opRepeat,
  input  logic       opSkipEq,
  input  logic       memReady,
  input  logic       rdMatch,
  input  logic       heldMatch,
  input  logic       cntLast,
  output ctlStrobe_t ctl,
  output logic       memRd,
  output logic       memWr,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNext;
  logic modeSearch, modeDown, modeRepeat, modeSkip;
  logic finishing;

  always_comb begin
    ctl          = '0;
    ctl.isSearch = modeSearch;
    ctl.down     = modeDown;
    memRd        = 1'b0;
    memWr        = 1'b0;
    finishing    = 1'b0;
    stateNext    = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctl.load  = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        memRd = 1'b1;
        if (memReady) begin
          ctl.capture = 1'b1;
          stateNext   = (modeSearch || (modeSkip && rdMatch)) ? ST_STEP : ST_WRITE;
        end
      end
      ST_WRITE: begin
        memWr      = 1'b1;
        ctl.useDst = 1'b1;
        if (memReady) begin
          stateNext = ST_STEP;
        end
      end
      ST_STEP: begin
        ctl.step = 1'b1;
        if (modeRepeat && !cntLast && !(modeSearch && heldMatch)) begin
          stateNext = ST_READ;
        end else begin
          finishing = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      modeSearch <= 1'b0;
      modeDown   <= 1'b0;
      modeRepeat <= 1'b0;
      modeSkip   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finishing;
      if (ctl.load) begin
        modeSearch <= opSearch;
        modeDown   <= opDown;
        modeRepeat <= opRepeat;
        modeSkip   <= opSkipEq && !opSearch;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdStart) |-> !ctl.load); // R11
  AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R1

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic          opSearch,
  input  logic          opDown,
  input  logic          opRepeat,
  input  logic          opSkipEq,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [CW-1:0] cntIn,
  input  logic [DW-1:0] accIn,
  output logic [AW-1:0] srcOut,
  output logic [AW-1:0] dstOut,
  output logic [CW-1:0] cntOut,
  output logic          flagZ,
  output logic          flagPv,
  output logic          flagH,
  output logic          flagN,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memReady
);

  ctlStrobe_t ctl;
  logic rdMatch, heldMatch, cntLast;

  blkmove_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .opSearch  (opSearch),
    .opDown    (opDown),
    .opRepeat  (opRepeat),
    .opSkipEq  (opSkipEq),
    .memReady  (memReady),
    .rdMatch   (rdMatch),
    .heldMatch (heldMatch),
    .cntLast   (cntLast),
    .ctl       (ctl),
    .memRd     (memRd),
    .memWr     (memWr),
    .busy      (busy),
    .done      (done)
  );

  blkmove_datapath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .initSrc   (srcIn),
    .initDst   (dstIn),
    .initCnt   (cntIn),
    .initAcc   (accIn),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .src       (srcOut),
    .dst       (dstOut),
    .cnt       (cntOut),
    .flagZ     (flagZ),
    .flagPv    (flagPv),
    .flagH     (flagH),
    .flagN     (flagN),
    .rdMatch   (rdMatch),
    .heldMatch (heldMatch),
    .cntLast   (cntLast)
  );

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> (memRd && $stable(memAddr) && $stable(cntOut))); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memReady) |=> (memWr && $stable(memAddr) && $stable(memWdata))); // R10

endmodule

// File: tb/tb_blkmove_engine.sv
module tb_blkmove_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic        opSearch = 1'b0, opDown = 1'b0, opRepeat = 1'b0, opSkipEq = 1'b0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  accIn = '0;
  logic [15:0] srcOut, dstOut, cntOut, memAddr;
  logic        flagZ, flagPv, flagH, flagN, busy, done, memRd, memWr;
  logic [7:0]  memWdata, memRdata;
  logic        memReady = 1'b1;

  always #10 clk = ~clk;

  blkmove_engine dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .opSearch(opSearch), .opDown(opDown),
    .opRepeat(opRepeat), .opSkipEq(opSkipEq), .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn),
    .accIn(accIn), .srcOut(srcOut), .dstOut(dstOut), .cntOut(cntOut), .flagZ(flagZ),
    .flagPv(flagPv), .flagH(flagH), .flagN(flagN), .busy(busy), .done(done),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  logic [7:0]  mem    [0:65535];
  logic [7:0]  refMem [0:65535];
  logic [15:0] rdQ[$];
  logic [23:0] wrQ[$];
  int          nTests = 0, nFails = 0;
  logic        stallOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prevStall = 1'b0, prevWasWr = 1'b0;
  logic [15:0] prevAddr = '0;
  logic        expZ = 1'b0, expPv = 1'b0, expH = 1'b0, expN = 1'b0;
  logic [15:0] expSrc, expDst, expCnt;

  assign memRdata = mem[memAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock bus comparison against the model's expected traffic
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(prevWasWr ? memWr : memRd, "R10 request held", 0, 1);
        check(memAddr == prevAddr, "R10 address held", memAddr, prevAddr);
      end
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memReady = stallOn ? (lfsr[0] | lfsr[1]) : 1'b1;
      check(!(memRd && memWr), "R1 no simultaneous rd/wr", {memRd, memWr}, 0);
      prevStall = (memRd || memWr) && !memReady;
      prevWasWr = memWr;
      prevAddr  = memAddr;
      if (memRd && memReady) begin
        if (rdQ.size() == 0) check(1'b0, "R4/R8 unexpected read", memAddr, 0);
        else begin
          logic [15:0] ea;
          ea = rdQ.pop_front();
          check(memAddr == ea, "R1/R2/R6 read address", memAddr, ea);
        end
      end
      if (memWr && memReady) begin
        if (wrQ.size() == 0) check(1'b0, "R5/R6 unexpected write", {memAddr, memWdata}, 0);
        else begin
          logic [23:0] ew;
          ew = wrQ.pop_front();
          check({memAddr, memWdata} == ew, "R1/R5 write addr+data", {memAddr, memWdata}, ew);
        end
        mem[memAddr] = memWdata;
      end
    end
  end

  task automatic model(input bit s, input bit dn, input bit rp, input bit sk,
                       input logic [15:0] hl, input logic [15:0] de,
                       input logic [15:0] bc, input logic [7:0] a);
    logic [7:0] b;
    bit more;
    for (int i = 0; i < 65536; i++) refMem[i] = mem[i];
    rdQ.delete();
    wrQ.delete();
    more = 1'b1;
    while (more) begin
      b = refMem[hl];
      rdQ.push_back(hl);
      if (s) begin
        expZ = (b == a);
        expH = (a[3:0] < b[3:0]);
        expN = 1'b1;
      end else begin
        if (!(sk && b == a)) begin
          wrQ.push_back({de, b});
          refMem[de] = b;
        end
        expH = 1'b0;
        expN = 1'b0;
        de = dn ? de - 16'd1 : de + 16'd1;
      end
      hl = dn ? hl - 16'd1 : hl + 16'd1;
      bc = bc - 16'd1;
      expPv = (bc != 0);
      more = rp && (bc != 0) && !(s && expZ);
    end
    expSrc = hl;
    expDst = de;
    expCnt = bc;
  endtask

  task automatic runOp(input string tag, input bit s, input bit dn, input bit rp, input bit sk,
                       input logic [15:0] hl, input logic [15:0] de, input logic [15:0] bc,
                       input logic [7:0] a, input bit stall, input bit poke);
    int cyc;
    model(s, dn, rp, sk, hl, de, bc, a);
    @(negedge clk);
    stallOn  = stall;
    opSearch = s; opDown = dn; opRepeat = rp; opSkipEq = sk;
    srcIn = hl; dstIn = de; cntIn = bc; accIn = a;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    check(busy == 1'b1, {tag, " busy after start"}, busy, 1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (poke && cyc == 3) begin
        check(busy == 1'b1, "R11 busy during poke", busy, 1);
        cmdStart = 1'b1; srcIn = 16'h1234; cntIn = 16'd1; opSearch = 1'b1;
      end else begin
        cmdStart = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    cmdStart = 1'b0;
    check(done == 1'b1, {tag, " done reached"}, done, 1);
    check(srcOut == expSrc, {tag, " source pointer"}, srcOut, expSrc);
    check(dstOut == expDst, {tag, " destination pointer"}, dstOut, expDst);
    check(cntOut == expCnt, {tag, " count"}, cntOut, expCnt);
    check(flagZ == expZ, {tag, " match flag"}, flagZ, expZ);
    check(flagPv == expPv, {tag, " R7 count-nonzero flag"}, flagPv, expPv);
    check(flagH == expH, {tag, " half-borrow flag"}, flagH, expH);
    check(flagN == expN, {tag, " subtract flag"}, flagN, expN);
    check(rdQ.size() == 0, {tag, " all reads issued"}, rdQ.size(), 0);
    check(wrQ.size() == 0, {tag, " all writes issued"}, wrQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done is one cycle", done, 0);
    check(busy == 1'b0, "R11 idle after done", busy, 0);
    stallOn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests + 1, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i ^ (i >> 8) * 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !memRd && !memWr, "R11 idle after reset", {busy, done, memRd, memWr}, 0);
    check(srcOut == 0 && dstOut == 0 && cntOut == 0, "R11 registers zero", cntOut, 0);
    check({flagZ, flagPv, flagH, flagN} == 4'b0, "R11 flags zero", {flagZ, flagPv, flagH, flagN}, 0);

    runOp("R1 single move up",        0, 0, 0, 0, 16'h0100, 16'h0200, 16'd5, 8'h00, 0, 0);
    runOp("R7 single move count 1",   0, 0, 0, 0, 16'h0110, 16'h0210, 16'd1, 8'h00, 0, 0);
    runOp("R2 single move down",      0, 1, 0, 0, 16'h0300, 16'h0400, 16'd3, 8'h00, 1, 0);
    runOp("R4 run move up stalled",   0, 0, 1, 0, 16'h1000, 16'h2000, 16'd6, 8'h00, 1, 0);
    runOp("R2 run move down wrap",    0, 1, 1, 0, 16'h0001, 16'h3003, 16'd4, 8'h00, 0, 0);
    mem[16'h4001] = 8'h55; mem[16'h4003] = 8'h55;
    runOp("R5 run move drop-equal",   0, 0, 1, 1, 16'h4000, 16'h5000, 16'd5, 8'h55, 1, 0);
    mem[16'h6000] = 8'h3A;
    runOp("R6 single scan match",     1, 0, 0, 0, 16'h6000, 16'h7777, 16'd9, 8'h3A, 0, 0);
    runOp("R3 move keeps match flag", 0, 0, 0, 0, 16'h6100, 16'h6200, 16'd2, 8'h00, 0, 0);
    mem[16'h6500] = 8'h0F;
    runOp("R6 scan half-borrow",      1, 0, 0, 0, 16'h6500, 16'h0000, 16'd4, 8'h20, 0, 0);
    for (int i = 0; i < 8; i++) mem[16'h6800 + i] = 8'h10 + 8'(i);
    runOp("R8 run scan match stop",   1, 0, 1, 0, 16'h6800, 16'h0000, 16'd8, 8'h13, 1, 0);
    runOp("R8 run scan count stop",   1, 1, 1, 0, 16'h6807, 16'h0000, 16'd5, 8'hEE, 0, 0);
    runOp("R9 zero count wraps",      0, 0, 0, 0, 16'h0700, 16'h0800, 16'd0, 8'h00, 0, 0);
    runOp("R11 start while busy",     0, 0, 1, 0, 16'h0900, 16'h0A00, 16'd7, 8'h00, 1, 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule